// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset request in a small controller into one system reset. Three requests come from inside the chip: an address trap, a watchdog expiry and a system-clock fault. Any of them makes the block pull a shared open-drain reset pad low for a fixed pulse of `2**CNT_EXP` oscillator clocks. The default exponent of 20 gives roughly 131 ms at 8 MHz. The pad carries a pull-up and has only two states: driven low or released. The same pad also serves as the external reset input. Its level is brought into the clock domain through a synchronizer chain, so a low from outside holds the system in reset.

A watchdog request can arrive while the high-frequency oscillator is stopped. In that case the block first asks for the oscillator to restart, and it counts the pulse only in high-frequency clocks. While the system reset is active, the block also supplies the values that core state takes at reset:
- a divider clear and a watchdog keep-enabled strobe
- register bank 0
- jump flag set
- master interrupt enable, individual enables and interrupt latches all clear
- the two vector addresses from which the program counter is fetched

The sequencer's own logic starts out requesting a full pulse, so a complete low pulse on the pad right after power-up is expected behaviour.

Top module: `rstseq_top`

## Requirements
- R1: A high level on `trap_req`, `wdt_req` or `clkf_req` sampled at a clock edge makes `pad_drive_low` high from that edge on.
- R2: Once the last request has been sampled, `pad_drive_low` stays high for exactly `2**CNT_EXP` counting clocks and then falls.
- R3: A new internal request during a pulse restarts the count, so the pad stays low for a full `2**CNT_EXP` counting clocks after the newest request.
- R4: A `wdt_req` sampled while `hf_osc_on` is low raises `hf_osc_start`. While `hf_osc_start` is high and `hf_osc_on` is low, the pulse does not count and does not end. `hf_osc_start` falls when the pulse ends.
- R5: An external low on `pad_in` raises `sys_rst` after two clock edges, through a two-stage synchronizer. `sys_rst` falls three edges after the pad returns high: two synchronizer stages plus one hold clock.
- R6: An external low on the pad never causes `pad_drive_low` to go high.
- R7: While `rst` is high, `pad_drive_low` is high. After `rst` falls, the pad stays low for a full `2**CNT_EXP` clocks, which models the uninitialized power-up pulse.
- R8: `pad_drive_low` high always implies `sys_rst` high.
- R9: While `sys_rst` is high, `div_clear` and `wdt_keep_en` are 1. Both are 0 outside reset.
- R10: The core values are constant: `bank_sel_init`=0, `jump_flag_init`=1, `ime_init`=0, `ie_init`=0, `il_init`=0, `vec_hi_addr`=16'hFFFF, `vec_lo_addr`=16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on clear; starts a full pulse |
| pad_in | input | 1 | Sensed level of the open-drain reset pad |
| trap_req | input | 1 | Address-trap reset request |
| wdt_req | input | 1 | Watchdog reset request |
| clkf_req | input | 1 | System-clock fault reset request |
| hf_osc_on | input | 1 | High-frequency oscillator running |
| pad_drive_low | output | 1 | Pad output enable; when high, the pad is sunk to 0, otherwise it is high impedance |
| hf_osc_start | output | 1 | Request to restart the high-frequency oscillator |
| sys_rst | output | 1 | Internal system reset |
| div_clear | output | 1 | Clear for the timing-generator divider |
| wdt_keep_en | output | 1 | Forces the watchdog enabled |
| bank_sel_init | output | BANK_W | Reset value of the register bank selector |
| jump_flag_init | output | 1 | Reset value of the jump status flag |
| ime_init | output | 1 | Reset value of the master interrupt enable |
| ie_init | output | IRQ_W | Reset value of the individual interrupt enables |
| il_init | output | IRQ_W | Reset value of the interrupt latches |
| vec_hi_addr | output | 16 | Address of the high byte of the reset vector |
| vec_lo_addr | output | 16 | Address of the low byte of the reset vector |

## Verification
The pulse length is measured at the pad for each of the three internal sources. Because these measurements give the same count, a source that is decoded wrongly or ignored stands out. A second request placed in the middle of a pulse separates a restarting counter from one that keeps running. A watchdog request with the oscillator stopped, held for several idle cycles before the oscillator starts, shows whether the block counts in the wrong clock. An external pad low of known length, with the bench's pull-up model looping the pad back, fixes the synchronizer latency on entry and the hold on exit. It also shows that an outside low never turns on the block's own drive.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int VEC_W = 16;

    // Reset-time values presented to the core.
    typedef struct packed {
        logic [VEC_W-1:0] vec_hi;
        logic [VEC_W-1:0] vec_lo;
        logic             jump_flag;
        logic             ime;
    } core_init_t;

    // Internal reset requests.
    typedef struct packed {
        logic trap;
        logic wdt;
        logic clkf;
    } int_req_t;

    function automatic core_init_t core_init_values();
        core_init_t v;
        v.vec_hi    = {VEC_W{1'b1}};
        v.vec_lo    = {{(VEC_W-1){1'b1}}, 1'b0};
        v.jump_flag = 1'b1;
        v.ime       = 1'b0;
        return v;
    endfunction

    function automatic logic any_req(input int_req_t r);
        return r.trap | r.wdt | r.clkf;
    endfunction

endpackage

// File: rtl/rstseq_pad_sync.sv
module rstseq_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_in,
    output logic pad_sync
);
    logic [STAGES-1:0] chain;

    // A released pad reads high through its pull-up, so the chain clears to ones.
    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pad_in};
    end

    assign pad_sync = chain[STAGES-1];
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch
    import rstseq_pkg::*;
#(
    parameter int CNT_EXP = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  int_req_t req,
    input  logic     hf_osc_on,
    output logic     active,
    output logic     wake_hf
);
    localparam int CW = CNT_EXP;
    localparam logic [CW-1:0] LAST = {CW{1'b1}};

    logic [CW-1:0] cnt;
    logic          cnt_en;

    // Counting waits for the high-frequency clock only after a slow-mode wake.
    assign cnt_en = active & (~wake_hf | hf_osc_on);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b1;
            cnt     <= '0;
            wake_hf <= 1'b0;
        end else if (any_req(req)) begin
            active <= 1'b1;
            cnt    <= '0;
            if (req.wdt && !hf_osc_on) wake_hf <= 1'b1;
        end else if (cnt_en) begin
            if (cnt == LAST) begin
                active  <= 1'b0;
                wake_hf <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rstseq_init.sv
module rstseq_init
    import rstseq_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int IRQ_W  = 8
) (
    input  logic              in_reset,
    output logic              div_clear,
    output logic              wdt_keep_en,
    output logic [BANK_W-1:0] bank_sel_init,
    output logic              jump_flag_init,
    output logic              ime_init,
    output logic [IRQ_W-1:0]  ie_init,
    output logic [IRQ_W-1:0]  il_init,
    output logic [VEC_W-1:0]  vec_hi_addr,
    output logic [VEC_W-1:0]  vec_lo_addr
);
    core_init_t iv;

    always_comb begin
        iv             = core_init_values();
        div_clear      = in_reset;
        wdt_keep_en    = in_reset;
        bank_sel_init  = '0;
        jump_flag_init = iv.jump_flag;
        ime_init       = iv.ime;
        ie_init        = '0;
        il_init        = '0;
        vec_hi_addr    = iv.vec_hi;
        vec_lo_addr    = iv.vec_lo;
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int CNT_EXP     = 20,
    parameter int SYNC_STAGES = 2,
    parameter int BANK_W      = 3,
    parameter int IRQ_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pad_in,
    input  logic              trap_req,
    input  logic              wdt_req,
    input  logic              clkf_req,
    input  logic              hf_osc_on,
    output logic              pad_drive_low,
    output logic              hf_osc_start,
    output logic              sys_rst,
    output logic              div_clear,
    output logic              wdt_keep_en,
    output logic [BANK_W-1:0] bank_sel_init,
    output logic              jump_flag_init,
    output logic              ime_init,
    output logic [IRQ_W-1:0]  ie_init,
    output logic [IRQ_W-1:0]  il_init,
    output logic [15:0]       vec_hi_addr,
    output logic [15:0]       vec_lo_addr
);
    int_req_t req;
    logic     pad_sync;
    logic     ext_low;
    logic     ext_hold;
    logic     active;

    assign req = '{trap: trap_req, wdt: wdt_req, clkf: clkf_req};

    rstseq_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .pad_sync (pad_sync)
    );

    rstseq_stretch #(.CNT_EXP(CNT_EXP)) u_stretch (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .hf_osc_on (hf_osc_on),
        .active    (active),
        .wake_hf   (hf_osc_start)
    );

    assign ext_low = ~pad_sync;

    // One extra clock of reset after the synchronized pad returns high.
    always_ff @(posedge clk) begin
        if (rst) ext_hold <= 1'b0;
        else     ext_hold <= ext_low;
    end

    assign pad_drive_low = active;
    assign sys_rst       = active | ext_low | ext_hold;

    rstseq_init #(.BANK_W(BANK_W), .IRQ_W(IRQ_W)) u_init (
        .in_reset       (sys_rst),
        .div_clear      (div_clear),
        .wdt_keep_en    (wdt_keep_en),
        .bank_sel_init  (bank_sel_init),
        .jump_flag_init (jump_flag_init),
        .ime_init       (ime_init),
        .ie_init        (ie_init),
        .il_init        (il_init),
        .vec_hi_addr    (vec_hi_addr),
        .vec_lo_addr    (vec_lo_addr)
    );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int CNT_EXP = 20
) (
    input logic clk,
    input logic rst,
    input logic trap_req,
    input logic wdt_req,
    input logic clkf_req,
    input logic hf_osc_on,
    input logic pad_drive_low,
    input logic hf_osc_start,
    input logic sys_rst,
    input logic div_clear,
    input logic wdt_keep_en
);
    localparam int CW = CNT_EXP + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << CNT_EXP;

    logic          any_req;
    logic [CW-1:0] seen;

    assign any_req = trap_req | wdt_req | clkf_req;

    // Counts the counting clocks since the newest request or the power-on clear.
    always_ff @(posedge clk) begin
        if (rst || any_req)
            seen <= '0;
        else if (pad_drive_low && (!hf_osc_start || hf_osc_on) && seen != FULL)
            seen <= seen + 1'b1;
    end

    p_req_drives_pad_r1: assert property (@(posedge clk) disable iff (rst)
        any_req |=> pad_drive_low);

    p_full_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_drive_low) |-> seen == FULL);

    p_slow_wake_r4: assert property (@(posedge clk) disable iff (rst)
        (wdt_req && !hf_osc_on) |=> hf_osc_start);

    p_slow_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pad_drive_low && hf_osc_start && !hf_osc_on) |=> pad_drive_low);

    p_ext_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
        (!pad_drive_low && !any_req) |=> !pad_drive_low);

    p_pad_in_reset_r8: assert property (@(posedge clk) disable iff (rst)
        pad_drive_low |-> sys_rst);

    p_strobes_r9: assert property (@(posedge clk) disable iff (rst)
        (div_clear == sys_rst) && (wdt_keep_en == sys_rst));
endmodule

bind rstseq_top rstseq_chk #(.CNT_EXP(CNT_EXP)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .trap_req      (trap_req),
    .wdt_req       (wdt_req),
    .clkf_req      (clkf_req),
    .hf_osc_on     (hf_osc_on),
    .pad_drive_low (pad_drive_low),
    .hf_osc_start  (hf_osc_start),
    .sys_rst       (sys_rst),
    .div_clear     (div_clear),
    .wdt_keep_en   (wdt_keep_en)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int EXP   = 4;
    localparam int PULSE = 1 << EXP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trap_req = 0, wdt_req = 0, clkf_req = 0, hf_osc_on = 1;
    logic ext_pull = 0;
    logic pad_in;
    logic pad_drive_low, hf_osc_start, sys_rst, div_clear, wdt_keep_en;
    logic [2:0] bank_sel_init;
    logic jump_flag_init, ime_init;
    logic [7:0] ie_init, il_init;
    logic [15:0] vec_hi_addr, vec_lo_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    // Pad model: pull-up, sunk by the block or by an outside source.
    assign pad_in = ~(pad_drive_low | ext_pull);

    rstseq_top #(.CNT_EXP(EXP)) u0 (
        .clk(clk), .rst(rst), .pad_in(pad_in),
        .trap_req(trap_req), .wdt_req(wdt_req), .clkf_req(clkf_req),
        .hf_osc_on(hf_osc_on), .pad_drive_low(pad_drive_low),
        .hf_osc_start(hf_osc_start), .sys_rst(sys_rst),
        .div_clear(div_clear), .wdt_keep_en(wdt_keep_en),
        .bank_sel_init(bank_sel_init), .jump_flag_init(jump_flag_init),
        .ime_init(ime_init), .ie_init(ie_init), .il_init(il_init),
        .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts negedges, starting at the current one, on which pad_drive_low is high.
    task automatic count_low(output int n);
        n = 0;
        while (pad_drive_low && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Waits for the reset tail to end and returns its length in negedges.
    task automatic count_sysrst(output int n);
        n = 0;
        while (sys_rst && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_power_on();
        int n;
        @(negedge clk);
        check("R7 pad low during rst", int'(pad_drive_low), 1);
        rst = 1'b0;
        count_low(n);
        check("R7 power-up pulse length", n, PULSE);
        count_sysrst(n);
        check("R5 tail after own pulse", n, 3);
        check("R9 div_clear idle", int'(div_clear), 0);
        check("R9 wdt_keep_en idle", int'(wdt_keep_en), 0);
    endtask

    task automatic t_internal(input int src);
        int n;
        @(negedge clk);
        check("R1 idle before request", int'(pad_drive_low), 0);
        case (src)
            0: trap_req = 1'b1;
            1: wdt_req  = 1'b1;
            default: clkf_req = 1'b1;
        endcase
        @(negedge clk);
        trap_req = 0; wdt_req = 0; clkf_req = 0;
        check("R1 pad driven after request", int'(pad_drive_low), 1);
        check("R8 sys_rst with pad", int'(sys_rst), 1);
        count_low(n);
        check("R2 pulse length", n, PULSE);
        count_sysrst(n);
    endtask

    task automatic t_restart();
        int n;
        @(negedge clk);
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        repeat (10) @(negedge clk);
        clkf_req = 1'b1;
        @(negedge clk);
        clkf_req = 1'b0;
        count_low(n);
        check("R3 restarted pulse length", n, PULSE);
        count_sysrst(n);
    endtask

    task automatic t_slow();
        int n;
        @(negedge clk);
        hf_osc_on = 1'b0;
        wdt_req   = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
        check("R4 oscillator restart request", int'(hf_osc_start), 1);
        repeat (PULSE + 5) @(negedge clk);
        check("R4 no count while stopped", int'(pad_drive_low), 1);
        hf_osc_on = 1'b1;
        count_low(n);
        check("R4 pulse in fast clocks", n, PULSE);
        check("R4 restart request cleared", int'(hf_osc_start), 0);
        count_sysrst(n);
    endtask

    task automatic t_external();
        int n;
        int drv;
        int first;
        drv = 0;
        first = -1;
        @(negedge clk);
        ext_pull = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (pad_drive_low) drv++;
            if (sys_rst && first < 0) first = i;
            @(negedge clk);
        end
        ext_pull = 1'b0;
        n = 0;
        while (sys_rst && n < 100) begin
            if (pad_drive_low) drv++;
            n++;
            @(negedge clk);
        end
        check("R5 synchronizer entry delay", first, 2);
        check("R5 tail after external release", n, 3);
        check("R6 no drive from external low", drv, 0);
    endtask

    task automatic t_init_values();
        @(negedge clk);
        ext_pull = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 div_clear in reset", int'(div_clear), 1);
        check("R9 wdt_keep_en in reset", int'(wdt_keep_en), 1);
        check("R10 bank selector", int'(bank_sel_init), 0);
        check("R10 jump flag", int'(jump_flag_init), 1);
        check("R10 master enable", int'(ime_init), 0);
        check("R10 enables", int'(ie_init), 0);
        check("R10 latches", int'(il_init), 0);
        check("R10 vector high address", int'(vec_hi_addr), 16'hFFFF);
        check("R10 vector low address", int'(vec_lo_addr), 16'hFFFE);
        ext_pull = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_power_on();
        t_internal(0);
        t_internal(1);
        t_internal(2);
        t_restart();
        t_slow();
        t_external();
        t_init_values();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule